// File: doc/BRIEF.md
# Mesh Zone Position Tracker

This block follows a raster-order pixel stream, one pixel per clock, and reports where each pixel falls on a rectangular correction mesh. For every accepted pixel it gives the mesh column and row of the box that holds the pixel. It also gives the linear address of that box's top-left mesh point, and two fixed-point weights that tell how far the pixel lies across the box horizontally and vertically. A downstream gain stage uses the address to fetch the four corner coefficients and the weights to blend them.

The geometry is programmable: a base box size in pixels and lines, the number of boxes in each direction, and three ramp increments per direction. The increments are one for a normal box, one for a box stretched by a step flag, and one for the final column or row. A small external table with one entry per mesh point, addressed by the same top-left point address, can stretch the current box by one pixel (bit 1) or by one line (bit 0). This lets frame sizes that are not exact multiples be covered without a remainder. All geometry writes go to shadow copies. A commit arms them, and they become live at the next accepted start of frame.

Top module: `mesh_pos_tracker`

## Requirements
- R1: After reset, pos_valid, stat_commit_pending and stat_busy are 0 and pix_ready is 1.
- R2: The column index starts at 0 on each line-start pixel and moves to the next column after box-width pixels. It never moves past column h_boxes-1, which absorbs the rest of the line.
- R3: When flag bit 1 is set for the current top-left point, the box is one pixel wider. While that box is covered, the horizontal weight uses the stretched increment.
- R4: The horizontal weight is 0 on the first pixel of each box and rises by the base increment per pixel. In the final column it rises by the last-column increment instead.
- R5: The row index and vertical weight start at 0 on the start-of-frame pixel and step on each later line-start pixel. Rows work like columns: box-height lines per row, flag bit 0 adds one line and selects the stretched increment, and the final row uses the last-row increment.
- R6: Both weights saturate at all-ones and never wrap within a box.
- R7: pt_addr equals row*(h_boxes+1)+column for the position of the most recently accepted pixel. flag_bits is read as the table entry for that address.
- R8: Register selects are: 0 box width, 1 box height, 2 horizontal box count, 3 vertical box count, 4/5/6 horizontal base/stretched/last increments, 7/8/9 vertical base/stretched/last increments, 10 commit. A write to selects 0 to 9 has no effect on the outputs until a commit is followed by an accepted start-of-frame.
- R9: A commit write sets stat_commit_pending. An accepted start-of-frame pixel copies the shadow values into the live set and clears the bit. If a commit write lands in the same cycle as that pixel, the bit stays set.
- R10: stat_busy goes to 1 after an accepted start-of-frame pixel and back to 0 after an accepted end-of-frame pixel.
- R11: While pos_valid is 1 and pos_ready is 0, pix_ready is 0, every output holds its value and no counter advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_sel | input | 4 | Register select |
| cfg_wr_data | input | DATA_W | Register write value |
| pix_valid | input | 1 | Input pixel present |
| pix_sof | input | 1 | Pixel is first of frame |
| pix_sol | input | 1 | Pixel is first of line |
| pix_eof | input | 1 | Pixel is last of frame |
| pix_ready | output | 1 | Block accepts a pixel this cycle |
| pt_addr | output | ADDR_W | Top-left mesh point address of the current box |
| flag_bits | input | 2 | Step flags for pt_addr: bit 1 widens, bit 0 heightens |
| pos_valid | output | 1 | Position outputs are valid |
| pos_ready | input | 1 | Downstream accepts the position |
| pos_col | output | CNT_W | Mesh column index |
| pos_row | output | CNT_W | Mesh row index |
| pos_hfrac | output | FRAC_W | Horizontal weight in the box |
| pos_vfrac | output | FRAC_W | Vertical weight in the box |
| stat_commit_pending | output | 1 | Committed values await a frame start |
| stat_busy | output | 1 | A frame is in progress |

## Verification
Two pairs of events can share a cycle. A commit write can coincide with the accepted start-of-frame pixel, and downstream stalls can fall on line-start pixels, where the row logic steps. The first is provoked by driving the commit on the very cycle the first pixel of a frame is taken. The bench then judges that the pending bit stays set and that the frame was still tracked with the earlier geometry. The second is provoked by streaming a whole frame under a repeating stall pattern. Every handed-over position is compared with a model built from the requirements, and any stalled cycle in which an output moves or pix_ready is high is counted as a failure.

// File: rtl/mpt_pkg.sv
package mpt_pkg;

   localparam int SEL_W = 4;

   typedef enum logic [SEL_W-1:0] {
      REG_BOX_PX   = 4'd0,
      REG_BOX_LN   = 4'd1,
      REG_H_BOXES  = 4'd2,
      REG_V_BOXES  = 4'd3,
      REG_H_INC    = 4'd4,
      REG_H_INC_ST = 4'd5,
      REG_H_INC_LS = 4'd6,
      REG_V_INC    = 4'd7,
      REG_V_INC_ST = 4'd8,
      REG_V_INC_LS = 4'd9,
      REG_COMMIT   = 4'd10
   } reg_sel_e;

   typedef enum logic [1:0] {
      INC_BASE    = 2'd0,
      INC_STRETCH = 2'd1,
      INC_LAST    = 2'd2
   } inc_sel_e;

endpackage

// File: rtl/mpt_cfg_regs.sv
module mpt_cfg_regs
   import mpt_pkg::*;
#(
   parameter int LEN_W  = 16,
   parameter int CNT_W  = 10,
   parameter int FRAC_W = 22,
   parameter int DATA_W = 22
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [SEL_W-1:0]     wr_sel,
   input  logic [DATA_W-1:0]    wr_data,
   input  logic                 frame_start,
   output logic [LEN_W-1:0]     act_box_px,
   output logic [LEN_W-1:0]     act_box_ln,
   output logic [CNT_W-1:0]     act_h_boxes,
   output logic [CNT_W-1:0]     act_v_boxes,
   output logic [2:0][FRAC_W-1:0] act_h_inc,
   output logic [2:0][FRAC_W-1:0] act_v_inc,
   output logic                 pending
);

   logic [LEN_W-1:0]        sh_box_px, sh_box_ln;
   logic [CNT_W-1:0]        sh_h_boxes, sh_v_boxes;
   logic [2:0][FRAC_W-1:0]  sh_h_inc, sh_v_inc;
   logic                    commit_wr;

   assign commit_wr = wr_en && (wr_sel == REG_COMMIT);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh_box_px  <= '0;
         sh_box_ln  <= '0;
         sh_h_boxes <= '0;
         sh_v_boxes <= '0;
         sh_h_inc   <= '0;
         sh_v_inc   <= '0;
      end else if (wr_en) begin
         case (wr_sel)
            REG_BOX_PX:   sh_box_px  <= wr_data[LEN_W-1:0];
            REG_BOX_LN:   sh_box_ln  <= wr_data[LEN_W-1:0];
            REG_H_BOXES:  sh_h_boxes <= wr_data[CNT_W-1:0];
            REG_V_BOXES:  sh_v_boxes <= wr_data[CNT_W-1:0];
            REG_H_INC:    sh_h_inc[INC_BASE]    <= wr_data[FRAC_W-1:0];
            REG_H_INC_ST: sh_h_inc[INC_STRETCH] <= wr_data[FRAC_W-1:0];
            REG_H_INC_LS: sh_h_inc[INC_LAST]    <= wr_data[FRAC_W-1:0];
            REG_V_INC:    sh_v_inc[INC_BASE]    <= wr_data[FRAC_W-1:0];
            REG_V_INC_ST: sh_v_inc[INC_STRETCH] <= wr_data[FRAC_W-1:0];
            REG_V_INC_LS: sh_v_inc[INC_LAST]    <= wr_data[FRAC_W-1:0];
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_box_px  <= '0;
         act_box_ln  <= '0;
         act_h_boxes <= '0;
         act_v_boxes <= '0;
         act_h_inc   <= '0;
         act_v_inc   <= '0;
         pending     <= 1'b0;
      end else begin
         if (frame_start && pending) begin
            act_box_px  <= sh_box_px;
            act_box_ln  <= sh_box_ln;
            act_h_boxes <= sh_h_boxes;
            act_v_boxes <= sh_v_boxes;
            act_h_inc   <= sh_h_inc;
            act_v_inc   <= sh_v_inc;
         end
         if (commit_wr)
            pending <= 1'b1;
         else if (frame_start)
            pending <= 1'b0;
      end
   end

   // R9: a frame start without a same-cycle commit leaves nothing pending
   p_pend_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start && !commit_wr |=> !pending);

   // R8: live geometry only moves on a frame start
   p_live_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_start |=> $stable(act_box_px) && $stable(act_h_boxes) && $stable(act_h_inc));

endmodule

// File: rtl/mpt_axis.sv
module mpt_axis
   import mpt_pkg::*;
#(
   parameter int LEN_W    = 16,
   parameter int CNT_W    = 10,
   parameter int FRAC_W   = 22,
   parameter bit FRAC_SAT = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    step,
   input  logic                    restart,
   input  logic                    stretch,
   input  logic [LEN_W-1:0]        box_len,
   input  logic [CNT_W-1:0]        box_cnt,
   input  logic [2:0][FRAC_W-1:0]  inc_set,
   output logic [CNT_W-1:0]        idx,
   output logic [LEN_W-1:0]        cnt,
   output logic [FRAC_W-1:0]       frac,
   output logic                    adv
);

   localparam logic [CNT_W:0] ONE_I = {{CNT_W{1'b0}}, 1'b1};
   localparam logic [LEN_W:0] ONE_L = {{LEN_W{1'b0}}, 1'b1};

   logic              is_last;
   logic              at_end;
   logic [LEN_W:0]    end_len;
   inc_sel_e          sel;
   logic [FRAC_W-1:0] inc;
   logic [FRAC_W:0]   sum;
   logic [FRAC_W-1:0] frac_nx;

   assign is_last = ({1'b0, idx} + ONE_I) >= {1'b0, box_cnt};
   assign end_len = {1'b0, box_len} + {{LEN_W{1'b0}}, stretch};
   assign at_end  = ({1'b0, cnt} + ONE_L) == end_len;
   assign adv     = step && !restart && at_end && !is_last;

   always_comb begin
      if (is_last)      sel = INC_LAST;
      else if (stretch) sel = INC_STRETCH;
      else              sel = INC_BASE;
      inc = inc_set[sel];
   end

   assign sum = {1'b0, frac} + {1'b0, inc};

   generate
      if (FRAC_SAT) begin : g_sat
         assign frac_nx = sum[FRAC_W] ? {FRAC_W{1'b1}} : sum[FRAC_W-1:0];
      end else begin : g_wrap
         assign frac_nx = sum[FRAC_W-1:0];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx  <= '0;
         cnt  <= '0;
         frac <= '0;
      end else if (step) begin
         if (restart) begin
            idx  <= '0;
            cnt  <= '0;
            frac <= '0;
         end else if (adv) begin
            idx  <= idx + ONE_I[CNT_W-1:0];
            cnt  <= '0;
            frac <= '0;
         end else begin
            cnt  <= (&cnt) ? cnt : cnt + ONE_L[LEN_W-1:0];
            frac <= frac_nx;
         end
      end
   end

   // R2/R5: a restart puts the index and weight back to zero
   p_restart_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
      step && restart |=> idx == '0 && frac == '0);

   // R2: the index stays inside the programmed box count
   p_idx_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
      box_cnt != '0 |-> idx < box_cnt);

   // R6: inside a box the weight never decreases
   p_frac_mono_r6: assert property (@(posedge clk) disable iff (!rst_n)
      FRAC_SAT && step && !restart && !adv |=> frac >= $past(frac));

endmodule

// File: rtl/mesh_pos_tracker.sv
module mesh_pos_tracker
   import mpt_pkg::*;
#(
   parameter int LEN_W    = 16,
   parameter int CNT_W    = 10,
   parameter int FRAC_W   = 22,
   parameter int ADDR_W   = 12,
   parameter bit FRAC_SAT = 1'b1,
   parameter int DATA_W   = (LEN_W > FRAC_W) ? LEN_W : FRAC_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_wr_en,
   input  logic [3:0]         cfg_wr_sel,
   input  logic [DATA_W-1:0]  cfg_wr_data,
   input  logic               pix_valid,
   input  logic               pix_sof,
   input  logic               pix_sol,
   input  logic               pix_eof,
   output logic               pix_ready,
   output logic [ADDR_W-1:0]  pt_addr,
   input  logic [1:0]         flag_bits,
   output logic               pos_valid,
   input  logic               pos_ready,
   output logic [CNT_W-1:0]   pos_col,
   output logic [CNT_W-1:0]   pos_row,
   output logic [FRAC_W-1:0]  pos_hfrac,
   output logic [FRAC_W-1:0]  pos_vfrac,
   output logic               stat_commit_pending,
   output logic               stat_busy
);

   localparam logic [ADDR_W-1:0] ONE_A = {{(ADDR_W-1){1'b0}}, 1'b1};

   initial begin
      assert (ADDR_W >= CNT_W) else $error("ADDR_W narrower than CNT_W");
      assert (FRAC_W >= 4 && LEN_W >= 2 && CNT_W >= 4) else $error("width too small");
      assert (DATA_W >= LEN_W && DATA_W >= FRAC_W) else $error("DATA_W too narrow");
   end

   logic                    acc, frame_start, line_start;
   logic [LEN_W-1:0]        act_box_px, act_box_ln;
   logic [CNT_W-1:0]        act_h_boxes, act_v_boxes;
   logic [2:0][FRAC_W-1:0]  act_h_inc, act_v_inc;
   logic [LEN_W-1:0]        h_cnt, v_cnt;
   logic                    h_adv, v_adv;
   logic [ADDR_W-1:0]       row_base;

   assign pix_ready   = pos_ready || !pos_valid;
   assign acc         = pix_valid && pix_ready;
   assign frame_start = acc && pix_sof;
   assign line_start  = pix_sol || pix_sof;

   mpt_cfg_regs #(
      .LEN_W(LEN_W), .CNT_W(CNT_W), .FRAC_W(FRAC_W), .DATA_W(DATA_W)
   ) cfg_i (
      .clk(clk), .rst_n(rst_n),
      .wr_en(cfg_wr_en), .wr_sel(cfg_wr_sel), .wr_data(cfg_wr_data),
      .frame_start(frame_start),
      .act_box_px(act_box_px), .act_box_ln(act_box_ln),
      .act_h_boxes(act_h_boxes), .act_v_boxes(act_v_boxes),
      .act_h_inc(act_h_inc), .act_v_inc(act_v_inc),
      .pending(stat_commit_pending)
   );

   mpt_axis #(
      .LEN_W(LEN_W), .CNT_W(CNT_W), .FRAC_W(FRAC_W), .FRAC_SAT(FRAC_SAT)
   ) h_axis_i (
      .clk(clk), .rst_n(rst_n),
      .step(acc), .restart(line_start), .stretch(flag_bits[1]),
      .box_len(act_box_px), .box_cnt(act_h_boxes), .inc_set(act_h_inc),
      .idx(pos_col), .cnt(h_cnt), .frac(pos_hfrac), .adv(h_adv)
   );

   mpt_axis #(
      .LEN_W(LEN_W), .CNT_W(CNT_W), .FRAC_W(FRAC_W), .FRAC_SAT(FRAC_SAT)
   ) v_axis_i (
      .clk(clk), .rst_n(rst_n),
      .step(acc && line_start), .restart(pix_sof), .stretch(flag_bits[0]),
      .box_len(act_box_ln), .box_cnt(act_v_boxes), .inc_set(act_v_inc),
      .idx(pos_row), .cnt(v_cnt), .frac(pos_vfrac), .adv(v_adv)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)
         row_base <= '0;
      else if (frame_start)
         row_base <= '0;
      else if (v_adv)
         row_base <= row_base + ADDR_W'(act_h_boxes) + ONE_A;
   end

   assign pt_addr = row_base + ADDR_W'(pos_col);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pos_valid <= 1'b0;
         stat_busy <= 1'b0;
      end else begin
         if (acc)            pos_valid <= 1'b1;
         else if (pos_ready) pos_valid <= 1'b0;
         if (acc && pix_eof) stat_busy <= 1'b0;
         else if (frame_start) stat_busy <= 1'b1;
      end
   end

   // R11: a stalled output holds and blocks the input
   p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      pos_valid && !pos_ready |=> pos_valid && $stable(pos_col) && $stable(pos_row)
                                  && $stable(pos_hfrac) && $stable(pos_vfrac) && $stable(h_cnt));

   // R2: a box change moves the column by exactly one
   p_col_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      h_adv |=> pos_col == $past(pos_col) + 1'b1 && pos_hfrac == '0);

   // R10: a frame start that is not also the end leaves the block busy
   p_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start && !pix_eof |=> stat_busy);

   // R5: row counting is frozen between line starts
   p_row_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !(acc && line_start) |=> $stable(v_cnt) && $stable(pos_row));

endmodule

// File: tb/mesh_pos_tracker_tb_top.sv
module mesh_pos_tracker_tb_top;
   import mpt_pkg::*;

   localparam int CLK_PERIOD = 10;
   localparam int FW = 22;
   localparam int CW = 10;
   localparam int AW = 12;
   localparam int W  = 28;
   localparam int H  = 18;
   localparam int NB = 8;
   localparam int BLN = 2;
   localparam int HI_B = 'h100000, HI_S = 'h0C0000, HI_L = 'h180000;
   localparam int VI_B = 'h200000, VI_S = 'h150000, VI_L = 'h1C0000;
   localparam int MAXF = 'h3FFFFF;

   // x, y, col, row, hfrac, vfrac, addr  (box width 3, R2-R7)
   localparam int VEC [8][7] = '{
      '{ 0,  0, 0, 0, 0,        0,        0},
      '{ 4,  1, 1, 0, 'h100000, 'h200000, 1},
      '{ 9,  4, 2, 1, 'h240000, 'h2A0000, 11},
      '{10,  5, 3, 2, 0,        0,        21},
      '{27, 17, 7, 7, 'h3FFFFF, 'h380000, 70},
      '{19, 16, 5, 7, 'h240000, 'h1C0000, 68},
      '{23,  8, 7, 3, 0,        'h200000, 34},
      '{22, 14, 6, 6, 'h200000, 'h200000, 60}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_wr_en = 1'b0;
   logic [3:0] cfg_wr_sel = '0;
   logic [FW-1:0] cfg_wr_data = '0;
   logic pix_valid = 1'b0, pix_sof = 1'b0, pix_sol = 1'b0, pix_eof = 1'b0;
   logic pix_ready;
   logic [AW-1:0] pt_addr;
   logic [1:0] flag_bits;
   logic pos_valid;
   logic pos_ready = 1'b1;
   logic [CW-1:0] pos_col, pos_row;
   logic [FW-1:0] pos_hfrac, pos_vfrac;
   logic stat_commit_pending, stat_busy;

   int total = 0, bad = 0;
   int cap_n = 0, hold_bad = 0;
   int cur_bpx = 3;
   bit zero_model = 1'b0;
   int cap_col[512], cap_row[512], cap_hf[512], cap_vf[512], cap_ad[512], cap_busy[512];
   bit prev_stall = 1'b0;
   int p_col = 0, p_row = 0, p_hf = 0, p_vf = 0;
   bit done = 1'b0;
   int stc = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mesh_pos_tracker dut_i (
      .clk(clk), .rst_n(rst_n),
      .cfg_wr_en(cfg_wr_en), .cfg_wr_sel(cfg_wr_sel), .cfg_wr_data(cfg_wr_data),
      .pix_valid(pix_valid), .pix_sof(pix_sof), .pix_sol(pix_sol), .pix_eof(pix_eof),
      .pix_ready(pix_ready), .pt_addr(pt_addr), .flag_bits(flag_bits),
      .pos_valid(pos_valid), .pos_ready(pos_ready),
      .pos_col(pos_col), .pos_row(pos_row), .pos_hfrac(pos_hfrac), .pos_vfrac(pos_vfrac),
      .stat_commit_pending(stat_commit_pending), .stat_busy(stat_busy)
   );

   function automatic bit hstr(input int c);
      return (c == 2) || (c == 5);
   endfunction

   function automatic bit vstr(input int r);
      return r == 1;
   endfunction

   // step-flag table: bit 1 widens mesh columns 2 and 5, bit 0 heightens row 1
   always_comb flag_bits = {hstr(int'(pt_addr) % (NB + 1)), vstr(int'(pt_addr) / (NB + 1))};

   function automatic void mdl(input int p, input int base, input bit horiz,
                               input int ib, input int is, input int il,
                               output int idx, output int fr);
      int start = 0;
      int len;
      int inc;
      longint prod;
      idx = 0;
      for (int c = 0; c < NB; c++) begin
         idx = c;
         len = base + int'(horiz ? hstr(c) : vstr(c));
         if (c == NB - 1 || p < start + len) break;
         start += len;
      end
      if (idx == NB - 1)                        inc = il;
      else if (horiz ? hstr(idx) : vstr(idx))   inc = is;
      else                                      inc = ib;
      prod = longint'(p - start) * longint'(inc);
      fr = (prod > MAXF) ? MAXF : int'(prod);
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   always begin
      @(negedge clk);
      #3;
      if (prev_stall) begin
         if (!pos_valid || int'(pos_col) != p_col || int'(pos_row) != p_row ||
             int'(pos_hfrac) != p_hf || int'(pos_vfrac) != p_vf)
            hold_bad++;
      end
      prev_stall = pos_valid && !pos_ready;
      if (prev_stall && pix_ready) hold_bad++;
      p_col = int'(pos_col); p_row = int'(pos_row);
      p_hf = int'(pos_hfrac); p_vf = int'(pos_vfrac);
      if (pos_valid && pos_ready) begin
         if (cap_n < 512) begin
            cap_col[cap_n] = int'(pos_col);
            cap_row[cap_n] = int'(pos_row);
            cap_hf[cap_n]  = int'(pos_hfrac);
            cap_vf[cap_n]  = int'(pos_vfrac);
            cap_ad[cap_n]  = int'(pt_addr);
            cap_busy[cap_n] = int'(stat_busy);
         end
         cap_n++;
      end
   end

   task automatic wr(input int sel, input int data);
      @(negedge clk); #1;
      cfg_wr_en = 1'b1; cfg_wr_sel = 4'(sel); cfg_wr_data = FW'(data);
      @(negedge clk); #1;
      cfg_wr_en = 1'b0;
   endtask

   task automatic push_frame(input bit stall, input bit commit_at_sof);
      bit go;
      cap_n = 0;
      for (int y = 0; y < H; y++) begin
         for (int x = 0; x < W; x++) begin
            go = 1'b0;
            while (!go) begin
               @(negedge clk); #1;
               stc++;
               pix_valid = 1'b1;
               pix_sof = (x == 0 && y == 0);
               pix_sol = (x == 0);
               pix_eof = (x == W - 1 && y == H - 1);
               pos_ready = !stall || (stc % 3 != 0);
               if (commit_at_sof && x == 0 && y == 0) begin
                  cfg_wr_en = 1'b1; cfg_wr_sel = REG_COMMIT;
               end else begin
                  cfg_wr_en = 1'b0;
               end
               #1 go = pix_ready;
            end
         end
      end
      @(negedge clk); #1;
      pix_valid = 1'b0; pix_sof = 1'b0; pix_sol = 1'b0; pix_eof = 1'b0;
      pos_ready = 1'b1; cfg_wr_en = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   task automatic compare_frame(input string tag);
      int ec, er, eh, ev, ea;
      int m_col = -1, m_hf = -1, m_row = -1, m_ad = -1;
      chk(cap_n == W * H, {tag, " R11 handshake count"}, cap_n, W * H);
      for (int k = 0; k < W * H; k++) begin
         if (zero_model) begin
            ec = 0; eh = 0; er = 0; ev = 0;
         end else begin
            mdl(k % W, cur_bpx, 1'b1, HI_B, HI_S, HI_L, ec, eh);
            mdl(k / W, BLN, 1'b0, VI_B, VI_S, VI_L, er, ev);
         end
         ea = er * (NB + 1) + ec;
         if (m_col < 0 && cap_col[k] != ec) m_col = k;
         if (m_hf  < 0 && cap_hf[k]  != eh) m_hf  = k;
         if (m_row < 0 && (cap_row[k] != er || cap_vf[k] != ev)) m_row = k;
         if (m_ad  < 0 && cap_ad[k]  != ea) m_ad  = k;
      end
      if (m_col < 0) chk(1'b1, "", 0, 0);
      else begin
         mdl(m_col % W, cur_bpx, 1'b1, HI_B, HI_S, HI_L, ec, eh);
         chk(1'b0, {tag, " R2/R3 column"}, cap_col[m_col], zero_model ? 0 : ec);
      end
      if (m_hf < 0) chk(1'b1, "", 0, 0);
      else begin
         mdl(m_hf % W, cur_bpx, 1'b1, HI_B, HI_S, HI_L, ec, eh);
         chk(1'b0, {tag, " R4/R6 hfrac"}, cap_hf[m_hf], zero_model ? 0 : eh);
      end
      if (m_row < 0) chk(1'b1, "", 0, 0);
      else begin
         mdl(m_row / W, BLN, 1'b0, VI_B, VI_S, VI_L, er, ev);
         chk(1'b0, {tag, " R5 row/vfrac"}, cap_row[m_row] * 'h1000000 + cap_vf[m_row],
             zero_model ? 0 : er * 'h1000000 + ev);
      end
      if (m_ad < 0) chk(1'b1, "", 0, 0);
      else chk(1'b0, {tag, " R7 point address"}, cap_ad[m_ad], -1);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk); #3;
      // R1: reset state
      chk(pos_valid == 1'b0, "R1 pos_valid", int'(pos_valid), 0);
      chk(stat_commit_pending == 1'b0 && stat_busy == 1'b0, "R1 status", int'({stat_commit_pending, stat_busy}), 0);
      chk(pix_ready == 1'b1, "R1 pix_ready", int'(pix_ready), 1);

      // R8: shadow writes without commit do not change anything
      wr(REG_BOX_PX, 3);  wr(REG_BOX_LN, BLN);
      wr(REG_H_BOXES, NB); wr(REG_V_BOXES, NB);
      wr(REG_H_INC, HI_B); wr(REG_H_INC_ST, HI_S); wr(REG_H_INC_LS, HI_L);
      wr(REG_V_INC, VI_B); wr(REG_V_INC_ST, VI_S); wr(REG_V_INC_LS, VI_L);
      chk(stat_commit_pending == 1'b0, "R8 no pending without commit", int'(stat_commit_pending), 0);
      zero_model = 1'b1;
      push_frame(1'b0, 1'b0);
      compare_frame("uncommitted R8");
      zero_model = 1'b0;

      // R9: commit arms, frame start applies
      wr(REG_COMMIT, 0);
      chk(stat_commit_pending == 1'b1, "R9 pending set", int'(stat_commit_pending), 1);
      push_frame(1'b0, 1'b0);
      chk(stat_commit_pending == 1'b0, "R9 pending cleared at frame start", int'(stat_commit_pending), 0);
      compare_frame("frame A");
      // R10: busy after first pixel, idle after last
      chk(cap_busy[0] == 1, "R10 busy after start of frame", cap_busy[0], 1);
      chk(cap_busy[W*H-1] == 0 && stat_busy == 1'b0, "R10 idle after end of frame", cap_busy[W*H-1], 0);
      for (int v = 0; v < 8; v++) begin
         int k;
         k = VEC[v][1] * W + VEC[v][0];
         chk(cap_col[k] == VEC[v][2] && cap_row[k] == VEC[v][3], "R2/R3/R5 table index",
             cap_col[k] * 1000 + cap_row[k], VEC[v][2] * 1000 + VEC[v][3]);
         chk(cap_hf[k] == VEC[v][4], "R4/R6 table hfrac", cap_hf[k], VEC[v][4]);
         chk(cap_vf[k] == VEC[v][5], "R5 table vfrac", cap_vf[k], VEC[v][5]);
         chk(cap_ad[k] == VEC[v][6], "R7 table address", cap_ad[k], VEC[v][6]);
      end

      // R11: same frame under a stall pattern
      hold_bad = 0;
      push_frame(1'b1, 1'b0);
      compare_frame("stalled R11");
      chk(hold_bad == 0, "R11 outputs held and pix_ready low while stalled", hold_bad, 0);

      // R9: commit in the same cycle as the frame start stays pending
      wr(REG_BOX_PX, 4);
      push_frame(1'b0, 1'b1);
      chk(stat_commit_pending == 1'b1, "R9 same-cycle commit stays pending", int'(stat_commit_pending), 1);
      compare_frame("old geometry R8");
      cur_bpx = 4;
      push_frame(1'b0, 1'b0);
      chk(stat_commit_pending == 1'b0, "R9 pending cleared next frame", int'(stat_commit_pending), 0);
      compare_frame("width 4 R2");
      chk(cap_col[4] == 1 && cap_hf[4] == 0, "R2 box width 4 boundary", cap_col[4], 1);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule